// File: doc/BRIEF.md
# Cached 32-bit Video Memory Writer

This block sits between a byte-wide processor register port and a byte-addressed video memory that is organised as 32-bit words with per-byte write enables. Software drives it through a handful of register indices. It can move single bytes through two data ports. Each port has its own address pointer, and each pointer has a programmable post-access step. A 32-bit cache can be loaded in two ways. Software can write the four cache bytes directly. It can also enable fill mode, in which every byte read through the second data port drops into the next cache slot.

With cached writes enabled, one write to the first data port commits a whole 32-bit word at the 4-byte-aligned address under pointer 0. The stored word is one of three things: the raw cache, the signed product of the two 16-bit cache halves, or that product added to a running accumulator. A transparency mode suppresses every zero byte, for both byte writes and cached writes. Copies, fills and fast multiplies all use the same store path.

A small state machine sequences each data-port access. The states are `ST_IDLE`, `ST_FETCH`, `ST_CAPTURE` and `ST_STORE`, with these transitions:
- idle→fetch on a data-port read;
- idle→store on a data-port write;
- fetch→capture always;
- capture→idle always;
- store→idle always.

`cpu_busy` is high in every state except idle, and commands are accepted only while it is low.

Register indices on `cpu_idx`:
- 0, 1 and 2 are the low, middle and high address bytes of the pointer picked by the control register's select bit.
- 3 is data port 0 and 4 is data port 1.
- 5 is the control register.
- 6 to 10 form a banked window.

Top module: `vram_cache_writer`

## Requirements
- R1: After reset, the control register, both pointers, both step codes, the FX settings, the multiply settings and all four cache bytes read as zero, `cpu_busy` is low, and no memory access is made.
- R2: Control bit 0 selects the pointer reached at indices 0–2, and control bits 4:1 select the bank for indices 6–10. In bank 2, index 6 is the FX control register (bit 7 transparency, bit 6 cached write, bit 5 fill; other bits read 0) and index 9 is the multiply register (bit 4 multiply, bit 5 accumulate). In bank 6, indices 6, 7, 8 and 9 are cache bytes low, mid, high and upper, where low is bits 7:0 of the cached word. Any other bank reads 0 at indices 6–10 and ignores writes there.
- R3: Bits 5:4 of the high address register hold the step code: 0 adds nothing, 1 adds 1, 2 adds 2, 3 adds 4. Bit 0 of that register is address bit 16. The pointer steps once after each data-port access that uses it.
- R4: Without cached write, a data-port write stores its byte to the lane given by address bits 1:0, and a data-port read returns the byte at the pointer. Data port 0 uses pointer 0 and data port 1 uses pointer 1.
- R5: With fill enabled, each data-port-1 read also loads the byte read into the current cache slot and advances the slot in the order low, mid, high, upper, then back to low.
- R6: A direct write to any cache byte returns the fill slot to low.
- R7: With cached write enabled, a data-port-0 write stores all four cache bytes in one access at pointer 0 with address bits 1:0 forced to zero. The byte value written to the port has no effect.
- R8: With multiply set, a cached write stores the signed 32-bit product of cache bits 15:0 and cache bits 31:16.
- R9: With multiply and accumulate both set, a cached write stores the accumulator plus the product, and that sum becomes the new accumulator. Reading index 10 in bank 6 returns 0 and clears the accumulator.
- R10: With transparency enabled, a byte of value zero is never written to memory, for byte writes and for cached writes alike.
- R11: A register read presents `cpu_rvalid` one cycle after the command. A data-port read presents it three cycles after the command. `cpu_busy` is high while a data-port access is in progress, and each access makes exactly one memory transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_idx | input | 4 | Register index |
| cpu_wr | input | 1 | Write command (taken only when not busy) |
| cpu_rd | input | 1 | Read command (taken only when not busy) |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte, valid with cpu_rvalid |
| cpu_rvalid | output | 1 | Read result strobe |
| cpu_busy | output | 1 | Data-port access in progress |
| mem_addr | output | AW-2 | Memory word address |
| mem_re | output | 1 | Memory read request, data returns next cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 4 | Per-byte write enables |
| mem_wdata | output | 32 | Memory write word |
| mem_rdata | input | 32 | Memory read word |

## Verification
The hardest state to reach from the ports is a cached store whose value depends on history. The cache has to be filled in a known slot order after a wrap and after a direct write, and the accumulator has to hold a sum from earlier stores. The stimulus first runs a copy that fills all four slots and then reads a fifth byte to force the wrap. Next, a direct cache write between two fill reads shows the slot reset. Finally, two back-to-back accumulating stores, then a clearing read and a third store, leave results in memory that are only correct if the accumulator carried over and was cleared. Every outcome is read back through the data ports and compared against a byte-level model kept in the bench.

// File: rtl/vcw_pkg.sv
package vcw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CAPTURE,
        ST_STORE
    } vcw_state_e;

    localparam logic [3:0] IDX_ADDR_L  = 4'd0;
    localparam logic [3:0] IDX_ADDR_M  = 4'd1;
    localparam logic [3:0] IDX_ADDR_H  = 4'd2;
    localparam logic [3:0] IDX_DATA0   = 4'd3;
    localparam logic [3:0] IDX_DATA1   = 4'd4;
    localparam logic [3:0] IDX_CTRL    = 4'd5;
    localparam logic [3:0] IDX_WIN0    = 4'd6;
    localparam logic [3:0] IDX_WIN3    = 4'd9;
    localparam logic [3:0] IDX_ACC_CLR = 4'd10;

    localparam logic [3:0] BANK_FX    = 4'd2;
    localparam logic [3:0] BANK_CACHE = 4'd6;

    // positions inside the 3-bit stored FX field (register bits 7:5)
    localparam int FXB_FILL  = 0;
    localparam int FXB_CWR   = 1;
    localparam int FXB_TRANS = 2;

    // positions inside the 2-bit stored multiply field (register bits 5:4)
    localparam int MLB_MUL = 0;
    localparam int MLB_ACC = 1;

    function automatic logic [2:0] step_of(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd0;
            2'd1:    return 3'd1;
            2'd2:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/vcw_pointer.sv
module vcw_pointer
    import vcw_pkg::*;
#(
    parameter int AW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_idx,
    input  logic [7:0]    wr_data,
    input  logic          step,
    input  logic [1:0]    rd_idx,
    output logic [AW-1:0] addr,
    output logic [7:0]    rd_data
);

    localparam int HB = AW - 16;

    logic [AW-1:0] addr_q;
    logic [1:0]    inc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            inc_q  <= '0;
        end else if (wr_en) begin
            case (wr_idx)
                2'd0: addr_q[7:0]     <= wr_data;
                2'd1: addr_q[15:8]    <= wr_data;
                2'd2: begin
                    addr_q[AW-1:16] <= wr_data[HB-1:0];
                    inc_q           <= wr_data[5:4];
                end
                default: ;
            endcase
        end else if (step) begin
            addr_q <= addr_q + AW'(step_of(inc_q));
        end
    end

    assign addr = addr_q;

    always_comb begin
        case (rd_idx)
            2'd0:    rd_data = addr_q[7:0];
            2'd1:    rd_data = addr_q[15:8];
            2'd2:    rd_data = {2'b00, inc_q, 4'(addr_q[AW-1:16])};
            default: rd_data = 8'h00;
        endcase
    end

endmodule

// File: rtl/vcw_cache.sv
module vcw_cache (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dwr_en,
    input  logic [1:0]  dwr_slot,
    input  logic [7:0]  dwr_data,
    input  logic        fill_en,
    input  logic [7:0]  fill_data,
    input  logic        acc_clr,
    input  logic        acc_upd,
    input  logic        mul_en,
    input  logic        acc_en,
    input  logic [1:0]  rd_slot,
    output logic [7:0]  rd_data,
    output logic [31:0] store_word
);

    logic [31:0]        cache_q;
    logic [1:0]         slot_q;
    logic [31:0]        acc_q;
    logic signed [31:0] prod;
    logic [31:0]        mul_word;

    assign prod     = $signed(cache_q[15:0]) * $signed(cache_q[31:16]);
    assign mul_word = acc_en ? (acc_q + prod) : prod;
    assign store_word = mul_en ? mul_word : cache_q;
    assign rd_data  = cache_q[{rd_slot, 3'b000} +: 8];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cache_q <= '0;
            slot_q  <= '0;
        end else if (dwr_en) begin
            cache_q[{dwr_slot, 3'b000} +: 8] <= dwr_data;
            slot_q <= 2'd0;
        end else if (fill_en) begin
            cache_q[{slot_q, 3'b000} +: 8] <= fill_data;
            slot_q <= slot_q + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (acc_clr) begin
            acc_q <= '0;
        end else if (acc_upd) begin
            acc_q <= mul_word;
        end
    end

endmodule

// File: rtl/vram_cache_writer.sv
module vram_cache_writer
    import vcw_pkg::*;
#(
    parameter int AW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    cpu_idx,
    input  logic          cpu_wr,
    input  logic          cpu_rd,
    input  logic [7:0]    cpu_wdata,
    output logic [7:0]    cpu_rdata,
    output logic          cpu_rvalid,
    output logic          cpu_busy,
    output logic [AW-3:0] mem_addr,
    output logic          mem_re,
    output logic          mem_we,
    output logic [3:0]    mem_be,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata
);

    localparam int NPTR = 2;

    vcw_state_e state_q, state_d;

    logic [4:0] ctrl_q;
    logic [2:0] fx_q;
    logic [1:0] mul_q;
    logic [3:0] bank;

    logic accept, cmd_wr, cmd_rd, idx_data, idx_win, step_en;
    logic op_port_q, op_cached_q;
    logic [7:0] op_byte_q;

    logic [AW-1:0] ptr_addr [NPTR];
    logic [7:0]    ptr_rd   [NPTR];
    logic [AW-1:0] cur_addr;
    logic [1:0]    lane;
    logic [7:0]    rd_byte;

    logic [1:0]  win_slot;
    logic [7:0]  cache_rd;
    logic [31:0] store_word;
    logic        cache_dwr, fill_en, acc_clr, acc_upd;

    logic [7:0] reg_rdata;
    logic [7:0] rdata_q;
    logic       rv_q;

    assign bank     = ctrl_q[4:1];
    assign accept   = (state_q == ST_IDLE);
    assign cmd_wr   = accept & cpu_wr;
    assign cmd_rd   = accept & cpu_rd & ~cpu_wr;
    assign idx_data = (cpu_idx == IDX_DATA0) || (cpu_idx == IDX_DATA1);
    assign idx_win  = (cpu_idx >= IDX_WIN0) && (cpu_idx <= IDX_WIN3);
    assign win_slot = cpu_idx[1:0] - 2'd2;
    assign step_en  = (state_q == ST_CAPTURE) || (state_q == ST_STORE);

    // ---------------- control, FX and multiply registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            fx_q   <= '0;
            mul_q  <= '0;
        end else if (cmd_wr) begin
            if (cpu_idx == IDX_CTRL) begin
                ctrl_q <= cpu_wdata[4:0];
            end
            if (bank == BANK_FX && cpu_idx == IDX_WIN0) begin
                fx_q <= cpu_wdata[7:5];
            end
            if (bank == BANK_FX && cpu_idx == IDX_WIN3) begin
                mul_q <= cpu_wdata[5:4];
            end
        end
    end

    // ---------------- latched data-port command ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_port_q   <= 1'b0;
            op_byte_q   <= '0;
            op_cached_q <= 1'b0;
        end else if ((cmd_wr || cmd_rd) && idx_data) begin
            op_port_q   <= (cpu_idx == IDX_DATA1);
            op_byte_q   <= cpu_wdata;
            op_cached_q <= cmd_wr && (cpu_idx == IDX_DATA0) && fx_q[FXB_CWR];
        end
    end

    // ---------------- address pointers ----------------
    for (genvar gi = 0; gi < NPTR; gi++) begin : g_ptr
        vcw_pointer #(.AW(AW)) u_ptr (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cmd_wr && (cpu_idx <= IDX_ADDR_H) && (ctrl_q[0] == 1'(gi))),
            .wr_idx  (cpu_idx[1:0]),
            .wr_data (cpu_wdata),
            .step    (step_en && (op_port_q == 1'(gi))),
            .rd_idx  (cpu_idx[1:0]),
            .addr    (ptr_addr[gi]),
            .rd_data (ptr_rd[gi])
        );
    end

    assign cur_addr = ptr_addr[op_port_q];
    assign lane     = cur_addr[1:0];
    assign rd_byte  = mem_rdata[{lane, 3'b000} +: 8];
    assign mem_addr = cur_addr[AW-1:2];

    // ---------------- cache, multiplier, accumulator ----------------
    assign cache_dwr = cmd_wr && (bank == BANK_CACHE) && idx_win;
    assign fill_en   = (state_q == ST_CAPTURE) && op_port_q && fx_q[FXB_FILL];
    assign acc_clr   = cmd_rd && (bank == BANK_CACHE) && (cpu_idx == IDX_ACC_CLR);
    assign acc_upd   = (state_q == ST_STORE) && op_cached_q
                     && mul_q[MLB_MUL] && mul_q[MLB_ACC];

    vcw_cache u_cache (
        .clk        (clk),
        .rst_n      (rst_n),
        .dwr_en     (cache_dwr),
        .dwr_slot   (win_slot),
        .dwr_data   (cpu_wdata),
        .fill_en    (fill_en),
        .fill_data  (rd_byte),
        .acc_clr    (acc_clr),
        .acc_upd    (acc_upd),
        .mul_en     (mul_q[MLB_MUL]),
        .acc_en     (mul_q[MLB_ACC]),
        .rd_slot    (win_slot),
        .rd_data    (cache_rd),
        .store_word (store_word)
    );

    // ---------------- register read mux ----------------
    always_comb begin
        reg_rdata = 8'h00;
        if (cpu_idx <= IDX_ADDR_H) begin
            reg_rdata = ptr_rd[ctrl_q[0]];
        end else if (cpu_idx == IDX_CTRL) begin
            reg_rdata = {3'b000, ctrl_q};
        end else if (idx_win && bank == BANK_FX) begin
            if (cpu_idx == IDX_WIN0) reg_rdata = {fx_q, 5'b00000};
            if (cpu_idx == IDX_WIN3) reg_rdata = {2'b00, mul_q, 4'b0000};
        end else if (idx_win && bank == BANK_CACHE) begin
            reg_rdata = cache_rd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rv_q    <= 1'b0;
            rdata_q <= '0;
        end else begin
            rv_q <= 1'b0;
            if (cmd_rd && !idx_data) begin
                rv_q    <= 1'b1;
                rdata_q <= reg_rdata;
            end else if (state_q == ST_CAPTURE) begin
                rv_q    <= 1'b1;
                rdata_q <= rd_byte;
            end
        end
    end

    assign cpu_rvalid = rv_q;
    assign cpu_rdata  = rdata_q;
    assign cpu_busy   = (state_q != ST_IDLE);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_wr && idx_data)      state_d = ST_STORE;
                else if (cmd_rd && idx_data) state_d = ST_FETCH;
            end
            ST_FETCH:   state_d = ST_CAPTURE;
            ST_CAPTURE: state_d = ST_IDLE;
            ST_STORE:   state_d = ST_IDLE;
        endcase
    end

    // ---------------- memory outputs ----------------
    always_comb begin
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_be    = 4'b0000;
        mem_wdata = '0;
        unique case (state_q)
            ST_FETCH: mem_re = 1'b1;
            ST_STORE: begin
                mem_we = 1'b1;
                if (op_cached_q) begin
                    mem_wdata = store_word;
                    mem_be    = 4'b1111;
                end else begin
                    mem_wdata = {4{op_byte_q}};
                    mem_be    = 4'b0001 << lane;
                end
                if (fx_q[FXB_TRANS]) begin
                    for (int b = 0; b < 4; b++) begin
                        if (mem_wdata[b*8 +: 8] == 8'h00) mem_be[b] = 1'b0;
                    end
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/vcw_chk.sv
module vcw_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] cpu_idx,
    input logic       cpu_wr,
    input logic       cpu_rd,
    input logic       cpu_busy,
    input logic       cpu_rvalid,
    input logic       mem_re,
    input logic       mem_we,
    input logic [3:0] mem_be,
    input logic       op_cached
);

    logic data_idx;
    assign data_idx = (cpu_idx == 4'd3) || (cpu_idx == 4'd4);

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we)); // R11

    AST_SINGLE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we); // R11

    AST_WRITE_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_busy && data_idx) |=> mem_we); // R4

    AST_READ_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_wr && !cpu_busy && data_idx) |=> mem_re); // R11

    AST_FETCH_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> ##2 cpu_rvalid); // R11

    AST_BYTE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !op_cached) |-> $onehot0(mem_be)); // R4

endmodule

bind vram_cache_writer vcw_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_idx    (cpu_idx),
    .cpu_wr     (cpu_wr),
    .cpu_rd     (cpu_rd),
    .cpu_busy   (cpu_busy),
    .cpu_rvalid (cpu_rvalid),
    .mem_re     (mem_re),
    .mem_we     (mem_we),
    .mem_be     (mem_be),
    .op_cached  (op_cached_q)
);

// File: tb/vram_cache_writer_test.sv
module vram_cache_writer_test;

    localparam int AW = 17;
    localparam logic [3:0] I_AL = 4'd0, I_AM = 4'd1, I_AH = 4'd2, I_D0 = 4'd3,
                           I_D1 = 4'd4, I_CT = 4'd5, I_W0 = 4'd6, I_W1 = 4'd7,
                           I_W2 = 4'd8, I_W3 = 4'd9, I_AC = 4'd10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [3:0]    cpu_idx = '0;
    logic          cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [7:0]    cpu_wdata = '0;
    logic [7:0]    cpu_rdata;
    logic          cpu_rvalid, cpu_busy;
    logic [AW-3:0] mem_addr;
    logic          mem_re, mem_we;
    logic [3:0]    mem_be;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;

    vram_cache_writer #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_idx(cpu_idx), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
        .cpu_busy(cpu_busy), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // memory the design drives, and the bench's own byte-level reference
    logic [31:0] bmem    [0:1023];
    logic [7:0]  ref_mem [0:4095];

    function automatic logic [7:0] pat(input int a);
        return 8'(a * 7 + 3);
    endfunction

    initial begin
        for (int a = 0; a < 4096; a++) ref_mem[a] = pat(a);
        for (int w = 0; w < 1024; w++)
            bmem[w] = {pat(w*4+3), pat(w*4+2), pat(w*4+1), pat(w*4)};
    end

    always @(posedge clk) begin
        if (mem_re) mem_rdata <= bmem[mem_addr[9:0]];
        if (mem_we) begin
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) bmem[mem_addr[9:0]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
        end
    end

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard: expected read bytes
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always @(negedge clk) begin
        if (rst_n && cpu_rvalid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 unexpected read strobe", int'(cpu_rdata), 0);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(cpu_rdata == e, t, int'(cpu_rdata), int'(e));
            end
        end
    end

    task automatic issue(input logic [3:0] idx, input bit wr, input logic [7:0] d);
        @(negedge clk);
        while (cpu_busy) @(negedge clk);
        cpu_idx = idx; cpu_wr = wr; cpu_rd = !wr; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_rd = 1'b0;
    endtask

    task automatic wr(input logic [3:0] idx, input logic [7:0] d);
        issue(idx, 1'b1, d);
    endtask

    task automatic rd(input logic [3:0] idx, input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        issue(idx, 1'b0, 8'h00);
    endtask

    task automatic bank(input logic [3:0] b, input bit sel);
        wr(I_CT, {3'b000, b, sel});
    endtask

    task automatic setp(input bit sel, input int a, input logic [1:0] inc);
        bank(4'd0, sel);
        wr(I_AL, 8'(a));
        wr(I_AM, 8'(a >> 8));
        wr(I_AH, {2'b00, inc, 3'b000, 1'(a >> 16)});
    endtask

    task automatic drain();
        for (int i = 0; i < 50 && (exp_q.size() != 0 || cpu_busy); i++) @(negedge clk);
    endtask

    task automatic readback(input int a, input int n, input string tag);
        setp(1'b0, a, 2'd1);
        for (int i = 0; i < n; i++) rd(I_D0, ref_mem[a+i], tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(cpu_busy == 1'b0, "R1 busy after reset", int'(cpu_busy), 0);
        check(mem_we == 1'b0 && mem_re == 1'b0, "R1 no memory access", int'({mem_we, mem_re}), 0);
        rd(I_CT, 8'h00, "R1 control");
        rd(I_AL, 8'h00, "R1 pointer0 low");
        rd(I_AH, 8'h00, "R1 pointer0 high");
        bank(4'd0, 1'b1);
        rd(I_AH, 8'h00, "R1 pointer1 high");
        bank(4'd6, 1'b0);
        rd(I_W0, 8'h00, "R1 cache low");
        rd(I_W3, 8'h00, "R1 cache upper");
        bank(4'd2, 1'b0);
        rd(I_W0, 8'h00, "R1 fx control");
        rd(I_W3, 8'h00, "R1 multiply");

        // R2 bank selection
        bank(4'd3, 1'b0);
        wr(I_W0, 8'h55);
        rd(I_W0, 8'h00, "R2 unmapped bank reads 0");
        bank(4'd6, 1'b0);
        rd(I_W0, 8'h00, "R2 unmapped bank write ignored");
        bank(4'd2, 1'b0);
        wr(I_W0, 8'hFF);
        rd(I_W0, 8'hE0, "R2 fx control bits");
        wr(I_W0, 8'h00);
        wr(I_W3, 8'hFF);
        rd(I_W3, 8'h30, "R2 multiply bits");
        rd(I_W1, 8'h00, "R2 fx bank unused index");
        wr(I_W3, 8'h00);

        // R3/R4 pointer steps and plain byte access
        setp(1'b0, 'h100, 2'd1);
        wr(I_D0, 8'h11); wr(I_D0, 8'h22); wr(I_D0, 8'h33);
        ref_mem['h100] = 8'h11; ref_mem['h101] = 8'h22; ref_mem['h102] = 8'h33;
        rd(I_AL, 8'h03, "R3 step of 1");
        readback('h100, 4, "R4 byte write and read");
        setp(1'b0, 'h200, 2'd0);
        wr(I_D0, 8'hA1); wr(I_D0, 8'hA2);
        ref_mem['h200] = 8'hA2;
        rd(I_D0, 8'hA2, "R3 step of 0 overwrites");
        rd(I_AL, 8'h00, "R3 step of 0 holds");
        setp(1'b0, 'h210, 2'd2);
        wr(I_D0, 8'hB1); wr(I_D0, 8'hB2);
        ref_mem['h210] = 8'hB1; ref_mem['h212] = 8'hB2;
        rd(I_AL, 8'h14, "R3 step of 2");
        setp(1'b0, 'h220, 2'd3);
        wr(I_D0, 8'hC1);
        ref_mem['h220] = 8'hC1;
        rd(I_AL, 8'h24, "R3 step of 4");
        rd(I_AH, 8'h30, "R3 high register step code");
        setp(1'b1, 'h210, 2'd1);
        rd(I_D1, 8'hB1, "R4 port1 read");
        rd(I_D1, ref_mem['h211], "R4 port1 read");
        rd(I_D1, 8'hB2, "R4 port1 read");
        bank(4'd0, 1'b0);
        rd(I_AL, 8'h24, "R3 pointer select keeps pointer0");

        // R5/R7 copy through the cache
        setp(1'b1, 'h100, 2'd1);
        setp(1'b0, 'h402, 2'd3);
        bank(4'd2, 1'b0);
        wr(I_W0, 8'h60);
        for (int i = 0; i < 4; i++) rd(I_D1, ref_mem['h100+i], "R5 fill read");
        wr(I_D0, 8'h99);
        for (int i = 0; i < 4; i++) ref_mem['h400+i] = ref_mem['h100+i];
        wr(I_W0, 8'h00);
        bank(4'd0, 1'b0);
        rd(I_AL, 8'h06, "R7 pointer steps 4 after cached write");
        bank(4'd6, 1'b0);
        rd(I_W0, 8'h11, "R5 slot low");
        rd(I_W1, 8'h22, "R5 slot mid");
        rd(I_W2, 8'h33, "R5 slot high");
        rd(I_W3, ref_mem['h103], "R5 slot upper");
        bank(4'd2, 1'b0);
        wr(I_W0, 8'h20);
        rd(I_D1, ref_mem['h104], "R5 fill read after wrap");
        wr(I_W0, 8'h00);
        bank(4'd6, 1'b0);
        rd(I_W0, ref_mem['h104], "R5 slot wraps to low");
        rd(I_W1, 8'h22, "R5 mid untouched by wrap");
        readback('h400, 5, "R7 aligned four-byte store");

        // R6 direct cache write resets fill slot
        bank(4'd6, 1'b0);
        wr(I_W1, 8'hEE);
        bank(4'd2, 1'b0);
        wr(I_W0, 8'h20);
        rd(I_D1, ref_mem['h105], "R6 fill read");
        wr(I_W0, 8'h00);
        bank(4'd6, 1'b0);
        rd(I_W0, ref_mem['h105], "R6 fill restarts at low");
        rd(I_W1, 8'hEE, "R6 direct byte kept");

        // R8 signed multiply
        bank(4'd6, 1'b0);
        wr(I_W0, 8'hFD); wr(I_W1, 8'hFF); wr(I_W2, 8'hE8); wr(I_W3, 8'h03);
        bank(4'd2, 1'b0);
        wr(I_W3, 8'h10);
        wr(I_W0, 8'h40);
        setp(1'b0, 'h500, 2'd3);
        wr(I_D0, 8'h00);
        ref_mem['h500] = 8'h48; ref_mem['h501] = 8'hF4;
        ref_mem['h502] = 8'hFF; ref_mem['h503] = 8'hFF;
        bank(4'd6, 1'b0);
        wr(I_W0, 8'h00); wr(I_W1, 8'h80); wr(I_W2, 8'h00); wr(I_W3, 8'h80);
        wr(I_D0, 8'h5A);
        ref_mem['h504] = 8'h00; ref_mem['h505] = 8'h00;
        ref_mem['h506] = 8'h00; ref_mem['h507] = 8'h40;
        bank(4'd2, 1'b0);
        wr(I_W0, 8'h00);
        wr(I_W3, 8'h00);
        readback('h500, 8, "R8 signed product");

        // R9 accumulate and clear
        bank(4'd6, 1'b0);
        wr(I_W0, 8'h07); wr(I_W1, 8'h00); wr(I_W2, 8'h05); wr(I_W3, 8'h00);
        rd(I_AC, 8'h00, "R9 clear read returns 0");
        bank(4'd2, 1'b0);
        wr(I_W3, 8'h30);
        wr(I_W0, 8'h40);
        setp(1'b0, 'h600, 2'd3);
        wr(I_D0, 8'h00);
        wr(I_D0, 8'h00);
        bank(4'd6, 1'b0);
        rd(I_AC, 8'h00, "R9 clear read returns 0");
        wr(I_D0, 8'h00);
        for (int i = 0; i < 12; i++) ref_mem['h600+i] = 8'h00;
        ref_mem['h600] = 8'h23; ref_mem['h604] = 8'h46; ref_mem['h608] = 8'h23;
        bank(4'd2, 1'b0);
        wr(I_W0, 8'h00);
        wr(I_W3, 8'h00);
        readback('h600, 12, "R9 accumulated stores");

        // R10 transparency
        bank(4'd2, 1'b0);
        wr(I_W0, 8'h80);
        setp(1'b0, 'h700, 2'd1);
        wr(I_D0, 8'h00);
        wr(I_D0, 8'h77);
        ref_mem['h701] = 8'h77;
        bank(4'd6, 1'b0);
        wr(I_W0, 8'h00); wr(I_W1, 8'h12); wr(I_W2, 8'h00); wr(I_W3, 8'h34);
        bank(4'd2, 1'b0);
        wr(I_W0, 8'hC0);
        setp(1'b0, 'h708, 2'd3);
        wr(I_D0, 8'h00);
        ref_mem['h709] = 8'h12; ref_mem['h70B] = 8'h34;
        bank(4'd2, 1'b0);
        wr(I_W0, 8'h00);
        readback('h700, 12, "R10 zero bytes skipped");

        // R11 read timing and busy
        drain();
        setp(1'b0, 'h700, 2'd1);
        drain();
        @(negedge clk);
        exp_q.push_back(ref_mem['h700]);
        tag_q.push_back("R11 data port read value");
        cpu_idx = I_D0; cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
        check(cpu_busy == 1'b1, "R11 busy during fetch", int'(cpu_busy), 1);
        check(cpu_rvalid == 1'b0, "R11 no early strobe", int'(cpu_rvalid), 0);
        @(negedge clk);
        check(cpu_rvalid == 1'b0, "R11 no early strobe", int'(cpu_rvalid), 0);
        @(negedge clk);
        check(cpu_rvalid == 1'b1, "R11 strobe at third cycle", int'(cpu_rvalid), 1);
        check(cpu_busy == 1'b0, "R11 idle after capture", int'(cpu_busy), 0);

        drain();
        check(exp_q.size() == 0, "R11 all reads returned", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule